// File: doc/BRIEF.md
# Camera Video Timing Generator

This block produces the three video qualifier strobes of a simulated camera source: frame valid, line valid and read valid. It runs on the pixel clock and keeps a horizontal counter (clocks within a raster) and a vertical counter (rasters within a frame). Both counters are exported with the strobes so a downstream pixel data path can pick its data from the same position. All geometry is taken from static configuration inputs. These inputs set the active pixel width and the tap count, the active line count, the horizontal and vertical blanking or total lengths, and a start and end clock position for each strobe.

Beyond free-running frames, the generator can emulate a line-scan sensor whose frame never closes. It can keep line valid pulsing through vertical blanking, and it can narrow read valid to a sub-window of line valid. It can also hold each frame or each raster until an edge arrives on one of two camera control inputs. The polarity of that edge can be selected. A stop input parks the generator in an idle state with all strobes low. Releasing the stop input starts the generator from the first clock of the first line.

Top module: `cam_timing_gen`

## Requirements
- R1: Active clocks per raster are `width >> tap_shift` (taps = 1, 2, 4 or 8 for `tap_shift` 0..3). When `hblank` is nonzero a raster lasts active clocks plus `hblank` clocks. When `hblank` is zero it lasts `total_w` clocks. `hcount` runs from 0 to the raster length minus one and then returns to 0.
- R2: When `vblank` is nonzero a frame holds `height + vblank` rasters. When `vblank` is zero it holds `total_h` rasters. `vcount` returns to 0 after the last raster.
- R3: Each strobe uses a horizontal window [start, end). An end value of 0 means start plus the active clock count. Line valid is high inside its window on active rasters (`vcount < height`). Frame valid rises at `fv_start` on raster 0 and falls at its end position on raster `height-1`. It stays high on every clock between those two points.
- R4: During vertical blanking rasters, line valid is low when `lv_cont` is 0. When `lv_cont` is 1, line valid repeats its normal horizontal window on those rasters.
- R5: When `linescan` is 1, every raster counts as active and the frame never ends. `vcount` keeps counting up and never wraps, and frame valid stays high once it has risen.
- R6: When `rv_en` is 0, read valid equals line valid. When `rv_en` is 1, read valid is line valid limited to the read window.
- R7: With `trig_frame` set, the generator waits with `hcount` at 0 and all strobes low before each frame until a trigger edge arrives. The first clock of the frame (hcount 0, strobes live) appears after the third rising clock edge that follows the input change. A level held across the wait does not release it: one edge releases one wait.
- R8: With `trig_line` set, the generator waits before every raster, with `hcount` at 0 and line valid low. During that wait `vcount` already shows the next raster, and frame valid stays high if the wait falls inside the frame.
- R9: The trigger source is `cc2` when `trig_sel` is 1 and `cc1` when it is 0. With `trig_pol` 1 a rising edge triggers, and with `trig_pol` 0 a falling edge triggers. Edges in the other direction have no effect, and neither do edges on the unselected input.
- R10: While `stop` is 1, the generator is idle after the next clock edge, with counters at 0 and every strobe low. Reset leaves it in the same idle state. The first clock edge that sees `stop` at 0 starts the first raster (or the trigger wait), and strobes follow from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop | input | 1 | Holds the generator idle while high |
| width | input | CW | Active pixels per raster |
| tap_shift | input | 2 | Log2 of the tap count |
| hblank | input | CW | Horizontal blanking clocks, 0 selects total_w |
| total_w | input | CW | Raster length used when hblank is 0 |
| height | input | VW | Active rasters per frame |
| vblank | input | VW | Vertical blanking rasters, 0 selects total_h |
| total_h | input | VW | Frame length used when vblank is 0 |
| fv_start | input | CW | Frame valid rise position on raster 0 |
| fv_end | input | CW | Frame valid fall position on the last active raster, 0 = auto |
| lv_start | input | CW | Line valid window start |
| lv_end | input | CW | Line valid window end, 0 = auto |
| rv_start | input | CW | Read valid window start |
| rv_end | input | CW | Read valid window end, 0 = auto |
| rv_en | input | 1 | Enables the separate read valid window |
| lv_cont | input | 1 | Line valid continues through vertical blanking |
| linescan | input | 1 | Endless frame mode |
| trig_frame | input | 1 | Wait for a trigger before each frame |
| trig_line | input | 1 | Wait for a trigger before each raster |
| trig_sel | input | 1 | Trigger source: 1 = cc2, 0 = cc1 |
| trig_pol | input | 1 | Trigger edge: 1 = rising, 0 = falling |
| cc1 | input | 1 | Camera control input 1 (asynchronous) |
| cc2 | input | 1 | Camera control input 2 (asynchronous) |
| fval | output | 1 | Frame valid |
| lval | output | 1 | Line valid |
| rval | output | 1 | Read valid |
| hcount | output | CW | Horizontal position in the raster |
| vcount | output | VW | Raster index in the frame |

## Verification
Two functions can fall in the same clock: the end of the last raster and the re-entry into the frame trigger wait. The trigger input is still held at its active level at that moment. The bench drives one edge, lets the whole frame run, and keeps the input high across the frame boundary. Correct behaviour is judged by line valid and `hcount` staying parked afterwards, because a stale level must not count as a fresh trigger. A second pairing is the end of a raster with line triggering inside a frame. There, frame valid must stay high while line valid drops, and `vcount` must already have advanced.

// File: rtl/cam_timing_gen.sv
module cam_timing_gen #(
  parameter int CW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop,
  input  logic [CW-1:0] width,
  input  logic [1:0]    tap_shift,
  input  logic [CW-1:0] hblank,
  input  logic [CW-1:0] total_w,
  input  logic [VW-1:0] height,
  input  logic [VW-1:0] vblank,
  input  logic [VW-1:0] total_h,
  input  logic [CW-1:0] fv_start,
  input  logic [CW-1:0] fv_end,
  input  logic [CW-1:0] lv_start,
  input  logic [CW-1:0] lv_end,
  input  logic [CW-1:0] rv_start,
  input  logic [CW-1:0] rv_end,
  input  logic          rv_en,
  input  logic          lv_cont,
  input  logic          linescan,
  input  logic          trig_frame,
  input  logic          trig_line,
  input  logic          trig_sel,
  input  logic          trig_pol,
  input  logic          cc1,
  input  logic          cc2,
  output logic          fval,
  output logic          lval,
  output logic          rval,
  output logic [CW-1:0] hcount,
  output logic [VW-1:0] vcount
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} state_t;
  state_t st;

  logic [CW-1:0] act, line_len, fve, lve, rve;
  logic [VW-1:0] frame_len, v_next;
  logic line_end, frame_end, running;
  logic s1, s2, s3, trig_hit;

  assign act       = width >> tap_shift;
  assign line_len  = (hblank != '0) ? act + hblank : total_w;
  assign frame_len = (vblank != '0) ? height + vblank : total_h;
  assign fve = (fv_end == '0) ? fv_start + act : fv_end;
  assign lve = (lv_end == '0) ? lv_start + act : lv_end;
  assign rve = (rv_end == '0) ? rv_start + act : rv_end;

  assign line_end  = hcount >= line_len - 1'b1;
  assign frame_end = !linescan && (vcount >= frame_len - 1'b1);
  assign v_next    = frame_end ? '0 : ((&vcount) ? vcount : vcount + 1'b1);
  assign running   = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= (trig_sel ? cc2 : cc1) ~^ trig_pol;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign trig_hit = s2 && !s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hcount <= '0;
      vcount <= '0;
    end else if (stop) begin
      st <= S_IDLE;
      hcount <= '0;
      vcount <= '0;
    end else begin
      case (st)
        S_IDLE: st <= (trig_frame || trig_line) ? S_WAIT : S_RUN;
        S_WAIT: if (trig_hit) st <= S_RUN;
        default: begin
          if (line_end) begin
            hcount <= '0;
            vcount <= v_next;
            if (trig_line || (trig_frame && frame_end)) st <= S_WAIT;
          end else begin
            hcount <= hcount + 1'b1;
          end
        end
      endcase
    end
  end

  logic active_line, first_line, last_line, fv_win, lv_win, rv_win;
  assign active_line = linescan || (vcount < height);
  assign first_line  = (vcount == '0);
  assign last_line   = !linescan && (vcount == height - 1'b1);
  assign fv_win = active_line && !(first_line && hcount < fv_start)
                              && !(last_line && hcount >= fve);
  assign lv_win = (hcount >= lv_start) && (hcount < lve);
  assign rv_win = (hcount >= rv_start) && (hcount < rve);

  assign fval = (running || (st == S_WAIT && vcount != '0)) && fv_win;
  assign lval = running && (active_line || lv_cont) && lv_win;
  assign rval = rv_en ? (lval && rv_win) : lval;

  assert_hcount_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !stop && hcount == line_len - 1'b1) |=> (hcount == '0));

  assert_blank_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lv_cont && !linescan && vcount >= height) |-> !lval);

  assert_scan_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (linescan && !stop && vcount != '0) |=> (vcount != '0));

  assert_rval_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rval |-> lval);

  assert_wait_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !trig_hit) |=> (hcount == '0 && !lval));

  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (hcount == '0 && vcount == '0 && !fval && !lval && !rval));

endmodule

// File: tb/cam_timing_gen_test.sv
`timescale 1ns/1ps
module cam_timing_gen_test;
  localparam int CW = 12;
  localparam int VW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop = 1'b1;
  logic [CW-1:0] width, hblank, total_w, fv_start, fv_end, lv_start, lv_end, rv_start, rv_end;
  logic [1:0] tap_shift;
  logic [VW-1:0] height, vblank, total_h;
  logic rv_en, lv_cont, linescan, trig_frame, trig_line, trig_sel, trig_pol, cc1, cc2;
  logic fval, lval, rval;
  logic [CW-1:0] hcount;
  logic [VW-1:0] vcount;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cam_timing_gen #(.CW(CW), .VW(VW)) uut (
    .clk(clk), .rst_n(rst_n), .stop(stop), .width(width), .tap_shift(tap_shift),
    .hblank(hblank), .total_w(total_w), .height(height), .vblank(vblank), .total_h(total_h),
    .fv_start(fv_start), .fv_end(fv_end), .lv_start(lv_start), .lv_end(lv_end),
    .rv_start(rv_start), .rv_end(rv_end), .rv_en(rv_en), .lv_cont(lv_cont),
    .linescan(linescan), .trig_frame(trig_frame), .trig_line(trig_line),
    .trig_sel(trig_sel), .trig_pol(trig_pol), .cc1(cc1), .cc2(cc2),
    .fval(fval), .lval(lval), .rval(rval), .hcount(hcount), .vcount(vcount));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pack(input int h, input int v, input bit f, input bit l, input bit r);
    return (v << 16) | (h << 3) | (int'(f) << 2) | (int'(l) << 1) | int'(r);
  endfunction

  task automatic restart();
    stop = 1'b1;
    repeat (4) @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic sweep_cfg(input int hb, input int vb, input bit lc, input bit re);
    int ll, fl, h, v;
    bit ef, el, er;
    hblank = CW'(hb); vblank = VW'(vb); lv_cont = lc; rv_en = re;
    linescan = 0; trig_frame = 0; trig_line = 0;
    restart();
    ll = (hb != 0) ? 4 + hb : 9;
    fl = (vb != 0) ? 3 + vb : 4;
    for (int t = 0; t < 2 * ll * fl; t++) begin
      @(negedge clk);
      h = t % ll;
      v = (t / ll) % fl;
      ef = (v < 3) && !(v == 0 && h < 1) && !(v == 2 && h >= 5);
      el = (v < 3 || lc) && h < 4;
      er = re ? (el && h >= 1 && h < 3) : el;
      chk(pack(hcount, vcount, fval, lval, rval) == pack(h, v, ef, el, er),
          "R1 R2 R3 R4 R6", "packed {v,h,fval,lval,rval}",
          pack(hcount, vcount, fval, lval, rval), pack(h, v, ef, el, er));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R10: actual %0d expected %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    width = 8; tap_shift = 1; total_w = 9; total_h = 4; height = 3;
    hblank = 3; vblank = 2;
    fv_start = 1; fv_end = 0; lv_start = 0; lv_end = 0; rv_start = 1; rv_end = 3;
    rv_en = 0; lv_cont = 0; linescan = 0; trig_frame = 0; trig_line = 0;
    trig_sel = 1; trig_pol = 1; cc1 = 0; cc2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fval && !lval && !rval && hcount == 0 && vcount == 0, "R10", "idle after reset",
        pack(hcount, vcount, fval, lval, rval), 0);

    for (int hb = 0; hb < 2; hb++)
      for (int vb = 0; vb < 2; vb++)
        for (int lc = 0; lc < 2; lc++)
          for (int re = 0; re < 2; re++)
            sweep_cfg(hb * 3, vb * 2, lc[0], re[0]);

    // R10: stop mid-run
    stop = 1'b1;
    @(negedge clk);
    chk(!fval && !lval && !rval && hcount == 0 && vcount == 0, "R10", "idle after stop",
        pack(hcount, vcount, fval, lval, rval), 0);

    // R5: linescan, frame never closes
    hblank = 3; vblank = 2; lv_cont = 0; rv_en = 0; linescan = 1;
    restart();
    for (int t = 0; t < 42; t++) begin
      int h, v;
      bit ef, el;
      @(negedge clk);
      h = t % 7; v = t / 7;
      ef = !(v == 0 && h < 1);
      el = h < 4;
      chk(pack(hcount, vcount, fval, lval, rval) == pack(h, v, ef, el, el), "R5", "linescan packed",
          pack(hcount, vcount, fval, lval, rval), pack(h, v, ef, el, el));
    end
    linescan = 0;

    // R7 / R9: frame trigger on cc2, rising
    trig_frame = 1; trig_sel = 1; trig_pol = 1; cc1 = 0; cc2 = 0;
    restart();
    repeat (20) @(negedge clk);
    chk(!fval && !lval && hcount == 0, "R7", "parked before trigger", pack(hcount, vcount, fval, lval, rval), 0);
    cc1 = 1;
    repeat (6) @(negedge clk);
    chk(!lval && hcount == 0, "R9", "unselected input ignored", pack(hcount, vcount, fval, lval, rval), 0);
    cc2 = 1;
    repeat (2) @(negedge clk);
    chk(!lval && hcount == 0, "R7", "still parked two edges after trigger", pack(hcount, vcount, fval, lval, rval), 0);
    @(negedge clk);
    chk(lval && hcount == 0 && vcount == 0, "R7", "frame starts third edge", pack(hcount, vcount, fval, lval, rval), pack(0, 0, 0, 1, 1));
    repeat (35) @(negedge clk);
    chk(!lval && !fval && hcount == 0 && vcount == 0, "R7", "parked at next frame", pack(hcount, vcount, fval, lval, rval), 0);
    repeat (10) @(negedge clk);
    chk(!lval && hcount == 0, "R7", "held level does not retrigger", pack(hcount, vcount, fval, lval, rval), 0);

    // R9: falling polarity; rising edge ignored
    stop = 1'b1; trig_pol = 0; cc2 = 0;
    repeat (5) @(negedge clk);
    stop = 1'b0;
    repeat (4) @(negedge clk);
    cc2 = 1;
    repeat (6) @(negedge clk);
    chk(!lval && hcount == 0, "R9", "wrong edge ignored", pack(hcount, vcount, fval, lval, rval), 0);
    cc2 = 0;
    repeat (3) @(negedge clk);
    chk(lval && hcount == 0, "R9", "falling edge triggers", pack(hcount, vcount, fval, lval, rval), pack(0, 0, 0, 1, 1));

    // R8: line trigger
    stop = 1'b1; trig_frame = 0; trig_line = 1; trig_pol = 1; cc2 = 0;
    repeat (5) @(negedge clk);
    stop = 1'b0;
    repeat (4) @(negedge clk);
    chk(!lval && !fval && hcount == 0 && vcount == 0, "R8", "parked before raster 0", pack(hcount, vcount, fval, lval, rval), 0);
    cc2 = 1;
    repeat (3) @(negedge clk);
    chk(lval && hcount == 0 && vcount == 0, "R8", "raster 0 starts", pack(hcount, vcount, fval, lval, rval), pack(0, 0, 0, 1, 1));
    repeat (7) @(negedge clk);
    chk(!lval && fval && hcount == 0 && vcount == 1, "R8", "mid-frame raster wait", pack(hcount, vcount, fval, lval, rval), pack(0, 1, 1, 0, 0));
    cc2 = 0;
    repeat (5) @(negedge clk);
    chk(!lval && hcount == 0 && vcount == 1, "R8", "falling edge ignored in wait", pack(hcount, vcount, fval, lval, rval), pack(0, 1, 1, 0, 0));
    cc2 = 1;
    repeat (3) @(negedge clk);
    chk(lval && fval && hcount == 0 && vcount == 1, "R8", "raster 1 starts", pack(hcount, vcount, fval, lval, rval), pack(0, 1, 1, 1, 1));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule